// File: doc/BRIEF.md
# Oversampled Setup/Hold Violation Detector

This block checks synchronously sampled channel groups for data that moves too close to the active clock edge. It runs on an oversampled timeline in which one clock cycle of the block stands for 0.5 ns of probe time. On every tick it receives the following inputs:

- the data bits of all groups;
- a flag that marks the tick on which the active sampling edge falls;
- a mode bit that says whether synchronous sampling is in force.

Each group has its own enable and its own settings, counted in ticks:

- a setup span, which looks back before the edge;
- a hold span, which looks ahead after it.

Each span reaches at most 16 ticks, which is 8 ns.

A group changes on a tick when its value differs from its value on the tick before. An edge violates for a group if the group changes on any tick inside that group's setup span or hold span. The hold span must close before the verdict is known. For that reason the block reports every edge a fixed number of cycles later. The report carries the data sample taken at the edge and one violation flag per group.

Top module: `shd_violation_detector`

## Requirements
- R1: While reset is asserted, valid_o, viol_o and sample_o are all zero.
- R2: When edge_i is high on the cycle of tick n and sync_mode_i is high, valid_o is high in cycle n+17, which is MAX_TICKS+1 cycles later. valid_o is low in every cycle not produced this way.
- R3: When valid_o is high, sample_o equals data_i as presented on the edge tick.
- R4: For an edge at tick E with setup setting S, a change of group g at any tick from E-S+1 through E, including the edge tick itself, sets viol_o[g].
- R5: For an edge at tick E with hold setting H, a change of group g at any tick from E+1 through E+H sets viol_o[g].
- R6: Changes at tick E-S or earlier, or at tick E+H+1 or later, do not set viol_o[g]. A change of any bit inside group g, bits g*GRP_W through g*GRP_W+GRP_W-1, counts as a change of that group only.
- R7: A setup setting of 0 checks no tick before or at the edge. A hold setting of 0 checks no tick after it. With both at 0, viol_o[g] stays low.
- R8: Setup and hold settings above MAX_TICKS (16) behave exactly as MAX_TICKS.
- R9: viol_o[g] is low whenever grp_en_i[g] is low.
- R10: With sync_mode_i low, valid_o and viol_o stay low.
- R11: Edges closer together than the combined window are each judged on their own, and the same change can flag several edges.
- R12: The first tick after reset release never counts as a change, whatever the data held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one cycle per 0.5 ns tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | High when synchronous sampling is in force |
| edge_i | input | 1 | Marks the tick on which the active clock edge falls |
| data_i | input | N_GRP*GRP_W | Data of all groups; group g occupies bits g*GRP_W upward |
| grp_en_i | input | N_GRP | Per-group enable for violation checking |
| setup_ticks_i | input | N_GRP*CFG_W | Per-group setup span in ticks, field g at bits g*CFG_W upward |
| hold_ticks_i | input | N_GRP*CFG_W | Per-group hold span in ticks, field g at bits g*CFG_W upward |
| valid_o | output | 1 | High for one cycle when an edge is reported |
| viol_o | output | N_GRP | Per-group violation flags for the reported edge |
| sample_o | output | N_GRP*GRP_W | Data sample taken at the reported edge |

## Verification
The assertions take for granted that sync_mode_i, grp_en_i and both setting buses hold steady over the span from an edge to its report. The block reads them only when the report is formed. The bench therefore changes configuration only while reset is held, and reset also clears the history, so no stale change from an older setting can reach a report. The assertions also take for granted that edge_i and data_i are sampled once per tick with no gaps. The bench drives a new value every cycle, including a quiet tail after each run so that the last edges are flushed.

// File: rtl/shd_pkg.sv
package shd_pkg;

  // Limit a programmed span to the largest span the history can hold.
  function automatic int clamp_ticks(input int val, input int lim);
    return (val > lim) ? lim : val;
  endfunction

  // History slot k holds the change seen k ticks before the report tick.
  // The edge sits max_t ticks back, so slots below max_t lie after the edge
  // (hold side) and slots from max_t upward lie at or before it (setup side).
  function automatic logic in_window(input int k, input int setup, input int hold,
                                     input int max_t);
    return ((k >= max_t - hold) && (k < max_t)) ||
           ((k >= max_t) && (k < max_t + setup));
  endfunction

endpackage

// File: rtl/shd_change_detect.sv
module shd_change_detect #(
  parameter int N_GRP = 4,
  parameter int GRP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_GRP*GRP_W-1:0] data_i,
  output logic [N_GRP-1:0]       chg_o
);

  logic [N_GRP*GRP_W-1:0] prev_q;
  logic                   primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= data_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign chg_o[g] = primed_q &&
                      (data_i[g*GRP_W +: GRP_W] != prev_q[g*GRP_W +: GRP_W]);
  end

endmodule

// File: rtl/shd_history.sv
module shd_history #(
  parameter int N_GRP     = 4,
  parameter int GRP_W     = 4,
  parameter int MAX_TICKS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_GRP-1:0]               chg_i,
  input  logic                           edge_i,
  input  logic [N_GRP*GRP_W-1:0]         data_i,
  output logic [N_GRP*2*MAX_TICKS-1:0]   hist_o,
  output logic                           edge_rpt_o,
  output logic [N_GRP*GRP_W-1:0]         data_rpt_o
);

  localparam int HIST_W = 2 * MAX_TICKS;
  localparam int DEPTH  = MAX_TICKS + 1;
  localparam int DW     = N_GRP * GRP_W;

  for (genvar g = 0; g < N_GRP; g++) begin : g_hist
    logic [HIST_W-1:0] chg_sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chg_sr <= '0;
      else        chg_sr <= {chg_sr[HIST_W-2:0], chg_i[g]};
    end
    assign hist_o[g*HIST_W +: HIST_W] = chg_sr;
  end

  logic [DEPTH-1:0] edge_sr;
  logic [DW-1:0]    data_sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sr <= '0;
      for (int k = 0; k < DEPTH; k++) data_sr[k] <= '0;
    end else begin
      edge_sr    <= {edge_sr[DEPTH-2:0], edge_i};
      data_sr[0] <= data_i;
      for (int k = 1; k < DEPTH; k++) data_sr[k] <= data_sr[k-1];
    end
  end

  assign edge_rpt_o = edge_sr[DEPTH-1];
  assign data_rpt_o = data_sr[DEPTH-1];

endmodule

// File: rtl/shd_window_eval.sv
module shd_window_eval #(
  parameter int MAX_TICKS = 16,
  parameter int CFG_W     = 5
) (
  input  logic [2*MAX_TICKS-1:0] hist_i,
  input  logic [CFG_W-1:0]       setup_i,
  input  logic [CFG_W-1:0]       hold_i,
  input  logic                   en_i,
  output logic                   hit_o
);
  import shd_pkg::*;

  localparam int HIST_W = 2 * MAX_TICKS;

  int                setup_eff;
  int                hold_eff;
  logic [HIST_W-1:0] win_mask;

  assign setup_eff = clamp_ticks(int'(setup_i), MAX_TICKS);
  assign hold_eff  = clamp_ticks(int'(hold_i), MAX_TICKS);

  for (genvar k = 0; k < HIST_W; k++) begin : g_slot
    assign win_mask[k] = in_window(k, setup_eff, hold_eff, MAX_TICKS);
  end

  assign hit_o = en_i && |(hist_i & win_mask);

endmodule

// File: rtl/shd_violation_detector.sv
module shd_violation_detector #(
  parameter int N_GRP     = 4,
  parameter int GRP_W     = 4,
  parameter int MAX_TICKS = 16,
  parameter int CFG_W     = $clog2(2 * MAX_TICKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_mode_i,
  input  logic                   edge_i,
  input  logic [N_GRP*GRP_W-1:0] data_i,
  input  logic [N_GRP-1:0]       grp_en_i,
  input  logic [N_GRP*CFG_W-1:0] setup_ticks_i,
  input  logic [N_GRP*CFG_W-1:0] hold_ticks_i,
  output logic                   valid_o,
  output logic [N_GRP-1:0]       viol_o,
  output logic [N_GRP*GRP_W-1:0] sample_o
);

  localparam int HIST_W = 2 * MAX_TICKS;
  localparam int DW     = N_GRP * GRP_W;

  logic [N_GRP-1:0]        grp_chg;
  logic [N_GRP*HIST_W-1:0] chg_hist;
  logic                    rpt_edge;
  logic [DW-1:0]           rpt_data;
  logic [N_GRP-1:0]        grp_hit;
  logic                    rpt_fire;

  shd_change_detect #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_i (data_i),
    .chg_o  (grp_chg)
  );

  shd_history #(.N_GRP(N_GRP), .GRP_W(GRP_W), .MAX_TICKS(MAX_TICKS)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .chg_i      (grp_chg),
    .edge_i     (edge_i),
    .data_i     (data_i),
    .hist_o     (chg_hist),
    .edge_rpt_o (rpt_edge),
    .data_rpt_o (rpt_data)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_eval
    shd_window_eval #(.MAX_TICKS(MAX_TICKS), .CFG_W(CFG_W)) u_win (
      .hist_i  (chg_hist[g*HIST_W +: HIST_W]),
      .setup_i (setup_ticks_i[g*CFG_W +: CFG_W]),
      .hold_i  (hold_ticks_i[g*CFG_W +: CFG_W]),
      .en_i    (grp_en_i[g]),
      .hit_o   (grp_hit[g])
    );
  end

  assign rpt_fire = rpt_edge && sync_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      viol_o   <= '0;
      sample_o <= '0;
    end else begin
      valid_o  <= rpt_fire;
      viol_o   <= rpt_fire ? grp_hit : '0;
      sample_o <= rpt_data;
    end
  end

endmodule

// File: rtl/shd_checker.sv
module shd_checker #(
  parameter int N_GRP     = 4,
  parameter int GRP_W     = 4,
  parameter int MAX_TICKS = 16,
  parameter int CFG_W     = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sync_mode_i,
  input logic                   edge_i,
  input logic [N_GRP*GRP_W-1:0] data_i,
  input logic [N_GRP-1:0]       grp_en_i,
  input logic [N_GRP*CFG_W-1:0] setup_ticks_i,
  input logic [N_GRP*CFG_W-1:0] hold_ticks_i,
  input logic                   valid_o,
  input logic [N_GRP-1:0]       viol_o,
  input logic [N_GRP*GRP_W-1:0] sample_o
);

  localparam int LAT = MAX_TICKS + 1;
  localparam int DW  = N_GRP * GRP_W;

  logic [LAT:0]  ref_edge;
  logic [DW-1:0] ref_data [LAT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_edge <= '0;
      for (int k = 0; k <= LAT; k++) ref_data[k] <= '0;
    end else begin
      ref_edge    <= {ref_edge[LAT-1:0], edge_i};
      ref_data[0] <= data_i;
      for (int k = 1; k <= LAT; k++) ref_data[k] <= ref_data[k-1];
    end
  end

  AST_REPORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == (ref_edge[LAT] && $past(sync_mode_i)));  // R2

  AST_SAMPLE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sample_o == ref_data[LAT]));  // R3

  AST_FLAG_NEEDS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (|viol_o) |-> valid_o);  // R10

  AST_NOSYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_mode_i) |-> (!valid_o && viol_o == '0));  // R10

  AST_DISABLED_GROUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o & ~$past(grp_en_i)) == '0);  // R9

  for (genvar g = 0; g < N_GRP; g++) begin : g_zero
    AST_ZERO_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(setup_ticks_i[g*CFG_W +: CFG_W] == '0 && hold_ticks_i[g*CFG_W +: CFG_W] == '0)
        |-> !viol_o[g]);  // R7
  end

endmodule

bind shd_violation_detector shd_checker #(
  .N_GRP(N_GRP), .GRP_W(GRP_W), .MAX_TICKS(MAX_TICKS), .CFG_W(CFG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_mode_i   (sync_mode_i),
  .edge_i        (edge_i),
  .data_i        (data_i),
  .grp_en_i      (grp_en_i),
  .setup_ticks_i (setup_ticks_i),
  .hold_ticks_i  (hold_ticks_i),
  .valid_o       (valid_o),
  .viol_o        (viol_o),
  .sample_o      (sample_o)
);

// File: tb/shd_violation_detector_tb.sv
module shd_violation_detector_tb;

  localparam int NG  = 4;
  localparam int GW  = 4;
  localparam int MT  = 16;
  localparam int CW  = 5;
  localparam int DW  = NG * GW;
  localparam int LAT = MT + 1;
  localparam int NT  = 700;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sync_mode_i = 1'b0;
  logic            edge_i = 1'b0;
  logic [DW-1:0]   data_i = '0;
  logic [NG-1:0]   grp_en_i = '0;
  logic [NG*CW-1:0] setup_ticks_i = '0;
  logic [NG*CW-1:0] hold_ticks_i = '0;
  logic            valid_o;
  logic [NG-1:0]   viol_o;
  logic [DW-1:0]   sample_o;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] st_data [NT];
  bit            st_edge [NT];
  int            n_len;
  int            cfg_s [NG];
  int            cfg_h [NG];
  bit [NG-1:0]   cfg_en;
  bit            cfg_sync;

  always #5 clk = ~clk;

  shd_violation_detector #(.N_GRP(NG), .GRP_W(GW), .MAX_TICKS(MT), .CFG_W(CW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_mode_i   (sync_mode_i),
    .edge_i        (edge_i),
    .data_i        (data_i),
    .grp_en_i      (grp_en_i),
    .setup_ticks_i (setup_ticks_i),
    .hold_ticks_i  (hold_ticks_i),
    .valid_o       (valid_o),
    .viol_o        (viol_o),
    .sample_o      (sample_o)
  );

  // A group changes at tick t when its value differs from tick t-1; tick 0 never counts (R12).
  function automatic bit changed_at(int t, int g);
    if (t < 1 || t >= n_len) return 1'b0;
    return st_data[t][g*GW +: GW] != st_data[t-1][g*GW +: GW];
  endfunction

  function automatic bit expect_flag(int e, int g);
    int s = (cfg_s[g] > MT) ? MT : cfg_s[g];
    int h = (cfg_h[g] > MT) ? MT : cfg_h[g];
    if (!cfg_sync || !cfg_en[g]) return 1'b0;
    for (int i = 0; i < s; i++) if (changed_at(e - i, g)) return 1'b1;
    for (int j = 1; j <= h; j++) if (changed_at(e + j, g)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic set_cfg(int smin, int smax, int hmin, int hmax);
    for (int g = 0; g < NG; g++) begin
      cfg_s[g] = smin + int'($urandom % (smax - smin + 1));
      cfg_h[g] = hmin + int'($urandom % (hmax - hmin + 1));
    end
  endtask

  task automatic gen_random(int n_act, int p_chg, int p_edge);
    logic [DW-1:0] d = DW'($urandom);
    n_len = n_act + LAT + 1;
    for (int t = 0; t < n_len; t++) begin
      if (t < n_act) begin
        for (int g = 0; g < NG; g++)
          if (($urandom % 100) < p_chg) d[g*GW + int'($urandom % GW)] ^= 1'b1;
        st_edge[t] = (($urandom % 100) < p_edge);
      end else begin
        st_edge[t] = 1'b0;
      end
      st_data[t] = d;
    end
  endtask

  task automatic check_tick(int e, string tag);
    bit exp_valid = st_edge[e] && cfg_sync;
    checks++;
    if (valid_o !== exp_valid) begin
      failures++;
      $display("FAIL R2 edge tick %0d valid_o actual=%b expected=%b", e, valid_o, exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (sample_o !== st_data[e]) begin
        failures++;
        $display("FAIL R3 edge tick %0d sample_o actual=%h expected=%h", e, sample_o, st_data[e]);
      end
    end
    for (int g = 0; g < NG; g++) begin
      bit exp_f = exp_valid && expect_flag(e, g);
      checks++;
      if (viol_o[g] !== exp_f) begin
        failures++;
        $display("FAIL %s edge tick %0d group %0d viol actual=%b expected=%b",
                 tag, e, g, viol_o[g], exp_f);
      end
    end
  endtask

  task automatic run_phase(string tag);
    rst_n = 1'b0;
    edge_i = 1'b0;
    sync_mode_i = cfg_sync;
    grp_en_i = cfg_en;
    for (int g = 0; g < NG; g++) begin
      setup_ticks_i[g*CW +: CW] = CW'(cfg_s[g]);
      hold_ticks_i[g*CW +: CW]  = CW'(cfg_h[g]);
    end
    repeat (2) @(negedge clk);
    checks++;  // R1 reset state
    if (valid_o !== 1'b0 || viol_o !== '0 || sample_o !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b/%h/%h expected=0/0/0", valid_o, viol_o, sample_o);
    end
    rst_n = 1'b1;
    for (int n = 0; n < n_len; n++) begin
      data_i = st_data[n];
      edge_i = st_edge[n];
      @(negedge clk);
      if (n - LAT >= 0) check_tick(n - LAT, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R4: setup side only
    cfg_sync = 1'b1; cfg_en = '1;
    set_cfg(1, 16, 0, 0); gen_random(300, 15, 20); run_phase("R4");

    // R5: hold side only
    set_cfg(0, 0, 1, 16); gen_random(300, 15, 20); run_phase("R5");

    // R6: directed boundaries, S=5 H=3; g0 at E-4 and g1 at E+3 inside, g2 at E-5 and g3 at E+4 outside
    for (int g = 0; g < NG; g++) begin cfg_s[g] = 5; cfg_h[g] = 3; end
    n_len = 180 + LAT + 1;
    for (int t = 0; t < n_len; t++) begin
      logic [DW-1:0] d = (t == 0) ? '0 : st_data[t-1];
      st_edge[t] = (t == 20 || t == 60 || t == 100 || t == 140);
      for (int k = 0; k < 4; k++) begin
        int e = 20 + 40 * k;
        if (t == e - 4) d[0]      ^= 1'b1;
        if (t == e + 3) d[GW]     ^= 1'b1;
        if (t == e - 5) d[2*GW]   ^= 1'b1;
        if (t == e + 4) d[3*GW+1] ^= 1'b1;
      end
      st_data[t] = d;
    end
    run_phase("R6");

    // R7: both spans zero with busy data
    set_cfg(0, 0, 0, 0); gen_random(200, 40, 30); run_phase("R7");

    // R8: oversized settings clamp to 16
    set_cfg(17, 31, 17, 31); gen_random(300, 8, 20); run_phase("R8");

    // R9: random group enables
    cfg_en = NG'($urandom); set_cfg(0, 16, 0, 16); gen_random(300, 15, 25); run_phase("R9");
    cfg_en = 4'b0101; gen_random(200, 15, 25); run_phase("R9");
    cfg_en = '1;

    // R10: sync mode off
    cfg_sync = 1'b0; set_cfg(1, 16, 1, 16); gen_random(200, 20, 30); run_phase("R10");
    cfg_sync = 1'b1;

    // R11: dense edges with overlapping windows
    set_cfg(8, 16, 8, 16); gen_random(300, 6, 60); run_phase("R11");

    // R12: nonzero data held from before release, edges at ticks 0 and 10, full windows
    for (int g = 0; g < NG; g++) begin cfg_s[g] = 16; cfg_h[g] = 16; end
    n_len = 60;
    for (int t = 0; t < n_len; t++) begin
      st_data[t] = '1;
      st_edge[t] = (t == 0 || t == 10);
    end
    run_phase("R12");

    // R6: mixed random rounds across all settings
    for (int r = 0; r < 3; r++) begin
      set_cfg(0, 24, 0, 24); gen_random(400, 5 + 10 * r, 15); run_phase("R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule